// File: doc/BRIEF.md
# I2C Target Responder with Status-Coded Handshake

This block is the target side of a two-wire serial bus controller. It watches the clock and data lines through synchronisers and recognises start and stop conditions. It compares each address byte against a programmable 7-bit address and takes part in the transfer only when the host has enabled acknowledgement. A local host controls the block through a small set of pins: an own-address byte, an acknowledge-enable level, a byte to transmit and a one-cycle flag-clear pulse.

Each phase of a transfer raises a single interrupt flag and posts an 8-bit status code. The phases are address matched, byte received, byte sent and acknowledged or refused, and end of transfer. While the flag is pending the block holds the clock line low, so the bus controller waits for the host. The host reads the code and, on a read transfer, places the next byte on the transmit pins. It then pulses the flag-clear input to let the transfer continue.

Top module: `i2cs_responder`

## Requirements
- R1: After reset, irq is 0, status reads 0xF8 and neither bus line is pulled low.
- R2: An address byte whose upper seven bits equal own_addr[7:1] with the direction bit (bit 0) at 0, received while ack_en is 1, is acknowledged by pulling SDA low during the ninth clock, and irq rises with status 0x60.
- R3: An address byte that does not match, or any address byte received while ack_en is 0, is not acknowledged, raises no irq and leaves the block not addressed.
- R4: A data byte received after a matched write address while ack_en is 1 is acknowledged, irq rises with status 0x80, and rx_data holds the byte with the first bit on the wire in bit 7.
- R5: A stop condition or a repeated start seen while addressed raises irq with status 0xA0 without holding SCL. After a repeated start, the next address byte is evaluated again.
- R6: A matched address byte with direction bit 1 gives status 0xA8. On the flag clear, tx_data is captured and sent MSB first, with SDA changing only while SCL is low.
- R7: After a byte is sent with ack_en 1 at load time, an acknowledge from the master gives status 0xB8 and the next flag clear loads a new byte. A refusal (SDA high in the ninth clock) gives status 0xC0, and the block then stops being addressed, so the following stop raises no irq.
- R8: A byte loaded while ack_en is 0 is the final byte: an acknowledge from the master gives status 0xC8, the block stops being addressed, and it answers its address again once ack_en is 1.
- R9: The general-call address byte 0x00 is accepted only when own_addr[0] is 1 and ack_en is 1. It gives status 0x70, and each data byte received after it gives status 0x90.
- R10: A data byte that completes while ack_en is 0 is not acknowledged. It gives status 0x88 (0x98 after a general call), rx_data still holds the byte, and the block stops being addressed.
- R11: SCL is pulled low while irq is set for every status except 0xA0. A one-cycle flag_clr pulse drops irq at the next edge, and SCL is released one cycle after that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Resolved level of the bus clock line |
| sda_in | input | 1 | Resolved level of the bus data line |
| scl_pull | output | 1 | 1 pulls the clock line low |
| sda_pull | output | 1 | 1 pulls the data line low |
| own_addr | input | 8 | [7:1] target address, [0] general-call accept |
| ack_en | input | 1 | Acknowledge enable; 0 ignores the address and refuses or ends bytes |
| tx_data | input | 8 | Byte to send, captured on flag clear after 0xA8 or 0xB8 |
| flag_clr | input | 1 | One-cycle pulse that clears irq and resumes the bus |
| irq | output | 1 | Event flag |
| status | output | 8 | Code of the most recent event |
| rx_data | output | 8 | Most recently received byte |

## Verification
The bench acts as a bus master that honours clock stretching. A scoreboard host answers each flag and compares the status and received byte with the values it expects. The bench sends a foreign address and its own address with acknowledge disabled; a design that compared too few address bits, or ignored the enable, would acknowledge these or raise a flag. It drives a read that ends in a master refusal and a read whose byte was loaded with acknowledge disabled, then sends a stop. A design that stayed addressed after either would post a stray 0xA0, and one that confused the two would return 0xB8 instead of 0xC0 or 0xC8. It also runs a general call followed by a repeated start to the own address, and a received byte with acknowledge disabled. A design that missed the repeated start, or acknowledged that byte, shows a missing 0xA0 or a master that sees an acknowledge.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  localparam logic [7:0] SC_NONE       = 8'hF8;
  localparam logic [7:0] SC_OWN_WR     = 8'h60;
  localparam logic [7:0] SC_GC_WR      = 8'h70;
  localparam logic [7:0] SC_RX_ACK     = 8'h80;
  localparam logic [7:0] SC_RX_NACK    = 8'h88;
  localparam logic [7:0] SC_GC_RX_ACK  = 8'h90;
  localparam logic [7:0] SC_GC_RX_NACK = 8'h98;
  localparam logic [7:0] SC_END        = 8'hA0;
  localparam logic [7:0] SC_OWN_RD     = 8'hA8;
  localparam logic [7:0] SC_TX_ACK     = 8'hB8;
  localparam logic [7:0] SC_TX_NACK    = 8'hC0;
  localparam logic [7:0] SC_TX_LAST    = 8'hC8;

  typedef enum logic [3:0] {
    PH_IDLE, PH_ADDR, PH_AACK, PH_RX, PH_RACK, PH_TX, PH_TACK, PH_HOLD, PH_SKIP
  } phase_t;
endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_cond,
  output logic stop_cond
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_prev, sda_prev;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe[0] <= scl_in;
          sda_pipe[0] <= sda_in;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
          sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_prev <= scl_pipe[STAGES-1];
      sda_prev <= sda_pipe[STAGES-1];
    end
  end

  assign scl_lvl    = scl_pipe[STAGES-1];
  assign sda_lvl    = sda_pipe[STAGES-1];
  assign scl_rise   = scl_lvl & ~scl_prev;
  assign scl_fall   = ~scl_lvl & scl_prev;
  // data edges only count as bus conditions while the clock stays high
  assign start_cond = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_cond  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/i2cs_addr_match.sv
module i2cs_addr_match (
  input  logic [7:0] addr_byte,
  input  logic [7:0] own_addr,
  input  logic       ack_en,
  output logic       hit_own,
  output logic       hit_gc
);
  always_comb begin
    hit_own = ack_en && (addr_byte[7:1] == own_addr[7:1]);
    hit_gc  = ack_en && own_addr[0] && (addr_byte == 8'h00) && !hit_own;
  end
endmodule

// File: rtl/i2cs_link_fsm.sv
module i2cs_link_fsm
  import i2cs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_lvl,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_cond,
  input  logic              stop_cond,
  input  logic              hit_own,
  input  logic              hit_gc,
  input  logic              ack_en,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              flag_clr,
  output logic [BYTE_W-1:0] addr_byte,
  output logic              flag,
  output logic [7:0]        status,
  output logic [BYTE_W-1:0] rx_data,
  output logic              scl_hold,
  output logic              sda_low
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  phase_t            ph, ph_n;
  logic [CNT_W-1:0]  cnt, cnt_n;
  logic [BYTE_W-1:0] sh, sh_n, rxd_n;
  logic              flag_n, hold_n, sdl_n;
  logic [7:0]        stat_n;
  logic              addressed, addr_n, gc, gc_n, last, last_n;
  logic              mack, mack_n, ackd, ackd_n;

  assign addr_byte = sh;

  always_comb begin
    ph_n   = ph;     cnt_n  = cnt;    sh_n   = sh;    rxd_n = rx_data;
    flag_n = flag;   stat_n = status; sdl_n  = sda_low;
    hold_n = scl_hold & flag;
    addr_n = addressed; gc_n = gc; last_n = last; mack_n = mack; ackd_n = ackd;

    if (flag && flag_clr) begin
      flag_n = 1'b0;
      if (ph == PH_HOLD) begin
        case (status)
          SC_OWN_RD, SC_TX_ACK: begin
            sh_n   = tx_data;
            sdl_n  = ~tx_data[BYTE_W-1];
            cnt_n  = '0;
            last_n = ~ack_en;
            ph_n   = PH_TX;
          end
          SC_OWN_WR, SC_GC_WR, SC_RX_ACK, SC_GC_RX_ACK: begin
            cnt_n = '0;
            ph_n  = PH_RX;
          end
          default: ph_n = PH_IDLE;
        endcase
      end
    end

    if (start_cond || stop_cond) begin
      if (addressed) begin
        flag_n = 1'b1;
        stat_n = SC_END;
        hold_n = 1'b0;
      end
      addr_n = 1'b0;
      gc_n   = 1'b0;
      sdl_n  = 1'b0;
      cnt_n  = '0;
      ph_n   = start_cond ? PH_ADDR : PH_IDLE;
    end else begin
      case (ph)
        PH_ADDR: begin
          if (scl_rise) begin
            sh_n  = {sh[BYTE_W-2:0], sda_lvl};
            cnt_n = cnt + 1'b1;
          end else if (scl_fall && cnt == LAST_BIT) begin
            if (hit_own || hit_gc) begin
              addr_n = 1'b1;
              gc_n   = hit_gc;
              sdl_n  = 1'b1;
              ph_n   = PH_AACK;
            end else begin
              ph_n = PH_SKIP;
            end
          end
        end
        PH_AACK: begin
          if (scl_fall) begin
            sdl_n  = 1'b0;
            flag_n = 1'b1;
            hold_n = 1'b1;
            stat_n = sh[0] ? SC_OWN_RD : (gc ? SC_GC_WR : SC_OWN_WR);
            ph_n   = PH_HOLD;
          end
        end
        PH_RX: begin
          if (scl_rise) begin
            sh_n  = {sh[BYTE_W-2:0], sda_lvl};
            cnt_n = cnt + 1'b1;
          end else if (scl_fall && cnt == LAST_BIT) begin
            rxd_n  = sh;
            ackd_n = ack_en;
            sdl_n  = ack_en;
            ph_n   = PH_RACK;
          end
        end
        PH_RACK: begin
          if (scl_fall) begin
            sdl_n  = 1'b0;
            flag_n = 1'b1;
            hold_n = 1'b1;
            if (ackd) stat_n = gc ? SC_GC_RX_ACK : SC_RX_ACK;
            else begin
              stat_n = gc ? SC_GC_RX_NACK : SC_RX_NACK;
              addr_n = 1'b0;
            end
            ph_n = PH_HOLD;
          end
        end
        PH_TX: begin
          if (scl_rise) begin
            cnt_n = cnt + 1'b1;
          end else if (scl_fall) begin
            if (cnt == LAST_BIT) begin
              sdl_n = 1'b0;
              ph_n  = PH_TACK;
            end else begin
              sh_n  = {sh[BYTE_W-2:0], 1'b0};
              sdl_n = ~sh[BYTE_W-2];
            end
          end
        end
        PH_TACK: begin
          if (scl_rise) begin
            mack_n = ~sda_lvl;
          end else if (scl_fall) begin
            flag_n = 1'b1;
            hold_n = 1'b1;
            if (!mack) begin
              stat_n = SC_TX_NACK;
              addr_n = 1'b0;
            end else if (last) begin
              stat_n = SC_TX_LAST;
              addr_n = 1'b0;
            end else begin
              stat_n = SC_TX_ACK;
            end
            ph_n = PH_HOLD;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= PH_IDLE;
      cnt       <= '0;
      sh        <= '0;
      rx_data   <= '0;
      flag      <= 1'b0;
      status    <= SC_NONE;
      scl_hold  <= 1'b0;
      sda_low   <= 1'b0;
      addressed <= 1'b0;
      gc        <= 1'b0;
      last      <= 1'b0;
      mack      <= 1'b0;
      ackd      <= 1'b0;
    end else begin
      ph        <= ph_n;
      cnt       <= cnt_n;
      sh        <= sh_n;
      rx_data   <= rxd_n;
      flag      <= flag_n;
      status    <= stat_n;
      scl_hold  <= hold_n;
      sda_low   <= sdl_n;
      addressed <= addr_n;
      gc        <= gc_n;
      last      <= last_n;
      mack      <= mack_n;
      ackd      <= ackd_n;
    end
  end

  AST_HOLD_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    scl_hold |-> (flag || $past(flag))); // R11
  AST_CLEAR_DROPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && flag_clr && scl_hold) |=> !flag); // R11
  AST_STATUS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_hold && $past(scl_hold)) |-> $stable(status)); // R11
  AST_ADDR_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addressed) |-> $past(ack_en)); // R3
  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_low) |-> !$past(scl_lvl)); // R6
endmodule

// File: rtl/i2cs_responder.sv
module i2cs_responder
  import i2cs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_pull,
  output logic       sda_pull,
  input  logic [7:0] own_addr,
  input  logic       ack_en,
  input  logic [7:0] tx_data,
  input  logic       flag_clr,
  output logic       irq,
  output logic [7:0] status,
  output logic [7:0] rx_data
);
  logic [1:0] rst_pipe;
  logic       rst_q;
  logic       scl_lvl, sda_lvl, scl_rise, scl_fall, start_cond, stop_cond;
  logic       hit_own, hit_gc;
  logic [7:0] addr_byte;

  // reset asserts at once, leaves after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  i2cs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_q), .scl_in(scl_in), .sda_in(sda_in),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_cond(start_cond), .stop_cond(stop_cond)
  );

  i2cs_addr_match u_match (
    .addr_byte(addr_byte), .own_addr(own_addr), .ack_en(ack_en),
    .hit_own(hit_own), .hit_gc(hit_gc)
  );

  i2cs_link_fsm u_fsm (
    .clk(clk), .rst_n(rst_q), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_cond(start_cond),
    .stop_cond(stop_cond), .hit_own(hit_own), .hit_gc(hit_gc),
    .ack_en(ack_en), .tx_data(tx_data), .flag_clr(flag_clr),
    .addr_byte(addr_byte), .flag(irq), .status(status), .rx_data(rx_data),
    .scl_hold(scl_pull), .sda_low(sda_pull)
  );
endmodule

// File: tb/tb_i2cs_responder.sv
module tb_i2cs_responder;
  localparam int H = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n;
  logic       m_scl_low, m_sda_low;
  logic       scl_pull, sda_pull, irq;
  logic [7:0] status, rx_data;
  logic [7:0] own_addr, tx_data;
  logic       ack_en, flag_clr;
  logic       scl_line, sda_line;

  assign scl_line = ~(m_scl_low | scl_pull);
  assign sda_line = ~(m_sda_low | sda_pull);

  i2cs_responder dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_line), .sda_in(sda_line),
    .scl_pull(scl_pull), .sda_pull(sda_pull), .own_addr(own_addr),
    .ack_en(ack_en), .tx_data(tx_data), .flag_clr(flag_clr),
    .irq(irq), .status(status), .rx_data(rx_data)
  );

  typedef struct {
    logic [7:0] code;
    logic [7:0] rx;
    logic [7:0] tx;
    logic       ack_after;
  } ev_t;

  ev_t exp_q[$];
  int  n_chk = 0;
  int  n_bad = 0;

  task automatic check_eq(string req, string what, logic [31:0] act, logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic finish_run;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  function automatic string req_of(logic [7:0] c);
    case (c)
      8'h60: return "R2";
      8'h80: return "R4";
      8'hA0: return "R5";
      8'hA8: return "R6";
      8'hB8, 8'hC0: return "R7";
      8'hC8: return "R8";
      8'h70, 8'h90: return "R9";
      8'h88, 8'h98: return "R10";
      default: return "R?";
    endcase
  endfunction

  function automatic ev_t mk(logic [7:0] c, logic [7:0] r, logic [7:0] t, logic a);
    ev_t e;
    e.code = c; e.rx = r; e.tx = t; e.ack_after = a;
    return e;
  endfunction

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic scl_up;
    m_scl_low = 1'b0;
    while (!scl_line) @(negedge clk);
  endtask

  task automatic bit_out(logic b);
    m_sda_low = ~b;
    wait_cyc(H);
    scl_up();
    wait_cyc(H);
    m_scl_low = 1'b1;
    wait_cyc(H);
  endtask

  task automatic bit_in(output logic b);
    m_sda_low = 1'b0;
    wait_cyc(H);
    scl_up();
    wait_cyc(H / 2);
    b = sda_line;
    wait_cyc(H / 2);
    m_scl_low = 1'b1;
    wait_cyc(H);
  endtask

  task automatic m_start;
    m_sda_low = 1'b0;
    wait_cyc(H);
    scl_up();
    wait_cyc(H);
    m_sda_low = 1'b1;
    wait_cyc(H);
    m_scl_low = 1'b1;
    wait_cyc(H);
  endtask

  task automatic m_stop;
    m_sda_low = 1'b1;
    wait_cyc(H);
    scl_up();
    wait_cyc(H);
    m_sda_low = 1'b0;
    wait_cyc(H);
  endtask

  task automatic send_byte(logic [7:0] b, output logic acked);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_in(a);
    acked = ~a;
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic give_ack);
    logic v;
    for (int i = 7; i >= 0; i--) begin
      bit_in(v);
      b[i] = v;
    end
    bit_out(~give_ack);
  endtask

  // scoreboard monitor acting as the host
  initial begin
    ev_t e;
    flag_clr = 1'b0;
    tx_data  = 8'h00;
    wait (rst_n === 1'b1);
    forever begin
      @(negedge clk);
      if (irq) begin
        if (exp_q.size() == 0) begin
          check_eq("R3", "unexpected irq status", {24'h0, status}, 32'hFFFF_FFFF);
          wait_cyc(4);
        end else begin
          e = exp_q.pop_front();
          check_eq(req_of(e.code), "status", {24'h0, status}, {24'h0, e.code});
          check_eq("R11", "scl hold while flagged", {31'h0, scl_pull},
                   {31'h0, (e.code != 8'hA0)});
          if (e.code inside {8'h80, 8'h88, 8'h90, 8'h98})
            check_eq(req_of(e.code), "rx_data", {24'h0, rx_data}, {24'h0, e.rx});
          wait_cyc(6);
          ack_en  = e.ack_after;
          tx_data = e.tx;
        end
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        check_eq("R11", "irq after clear", {31'h0, irq}, 32'h0);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic       ak;
    logic [7:0] got;
    rst_n = 1'b0;
    m_scl_low = 1'b0;
    m_sda_low = 1'b0;
    own_addr  = 8'h74;
    ack_en    = 1'b1;
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(5);
    // R1 reset state
    check_eq("R1", "irq", {31'h0, irq}, 32'h0);
    check_eq("R1", "status", {24'h0, status}, 32'hF8);
    check_eq("R1", "scl_pull", {31'h0, scl_pull}, 32'h0);
    check_eq("R1", "sda_pull", {31'h0, sda_pull}, 32'h0);

    // R2 R4 R5: write two bytes then stop
    exp_q.push_back(mk(8'h60, 8'h00, 8'h00, 1'b1));
    exp_q.push_back(mk(8'h80, 8'hC3, 8'h00, 1'b1));
    exp_q.push_back(mk(8'h80, 8'h5E, 8'h00, 1'b1));
    exp_q.push_back(mk(8'hA0, 8'h00, 8'h00, 1'b1));
    m_start();
    send_byte(8'h74, ak); check_eq("R2", "address ack", {31'h0, ak}, 32'h1);
    send_byte(8'hC3, ak); check_eq("R4", "data ack", {31'h0, ak}, 32'h1);
    send_byte(8'h5E, ak); check_eq("R4", "data ack", {31'h0, ak}, 32'h1);
    m_stop();
    wait_cyc(40);

    // R3: foreign address
    m_start();
    send_byte(8'h52, ak); check_eq("R3", "foreign address nack", {31'h0, ak}, 32'h0);
    m_stop();
    wait_cyc(40);
    check_eq("R3", "no irq after foreign address", {31'h0, irq}, 32'h0);

    // R3: own address with ack_en low
    ack_en = 1'b0;
    m_start();
    send_byte(8'h74, ak); check_eq("R3", "disabled address nack", {31'h0, ak}, 32'h0);
    m_stop();
    wait_cyc(40);
    check_eq("R3", "no irq while disabled", {31'h0, irq}, 32'h0);
    ack_en = 1'b1;

    // R6 R7: read two bytes, master refuses the second
    exp_q.push_back(mk(8'hA8, 8'h00, 8'hA5, 1'b1));
    exp_q.push_back(mk(8'hB8, 8'h00, 8'h3C, 1'b1));
    exp_q.push_back(mk(8'hC0, 8'h00, 8'h00, 1'b1));
    m_start();
    send_byte(8'h75, ak); check_eq("R6", "read address ack", {31'h0, ak}, 32'h1);
    recv_byte(got, 1'b1); check_eq("R6", "first read byte", {24'h0, got}, 32'hA5);
    recv_byte(got, 1'b0); check_eq("R7", "second read byte", {24'h0, got}, 32'h3C);
    m_stop();
    wait_cyc(40);

    // R8: final byte, then answers again
    exp_q.push_back(mk(8'hA8, 8'h00, 8'h96, 1'b0));
    exp_q.push_back(mk(8'hC8, 8'h00, 8'h00, 1'b1));
    m_start();
    send_byte(8'h75, ak); check_eq("R8", "read address ack", {31'h0, ak}, 32'h1);
    recv_byte(got, 1'b1); check_eq("R8", "final byte", {24'h0, got}, 32'h96);
    m_stop();
    wait_cyc(40);
    exp_q.push_back(mk(8'h60, 8'h00, 8'h00, 1'b1));
    exp_q.push_back(mk(8'hA0, 8'h00, 8'h00, 1'b1));
    m_start();
    send_byte(8'h74, ak); check_eq("R8", "answers after final byte", {31'h0, ak}, 32'h1);
    m_stop();
    wait_cyc(40);

    // R9 R5: general call, repeated start to own address
    own_addr = 8'h75;
    exp_q.push_back(mk(8'h70, 8'h00, 8'h00, 1'b1));
    exp_q.push_back(mk(8'h90, 8'h11, 8'h00, 1'b1));
    exp_q.push_back(mk(8'hA0, 8'h00, 8'h00, 1'b1));
    exp_q.push_back(mk(8'h60, 8'h00, 8'h00, 1'b1));
    exp_q.push_back(mk(8'h80, 8'h22, 8'h00, 1'b1));
    exp_q.push_back(mk(8'hA0, 8'h00, 8'h00, 1'b1));
    m_start();
    send_byte(8'h00, ak); check_eq("R9", "general call ack", {31'h0, ak}, 32'h1);
    send_byte(8'h11, ak); check_eq("R9", "general call data ack", {31'h0, ak}, 32'h1);
    m_start();
    send_byte(8'h74, ak); check_eq("R5", "address after repeated start", {31'h0, ak}, 32'h1);
    send_byte(8'h22, ak); check_eq("R4", "data ack", {31'h0, ak}, 32'h1);
    m_stop();
    wait_cyc(40);

    // R9: general call refused when own_addr[0] is 0
    own_addr = 8'h74;
    m_start();
    send_byte(8'h00, ak); check_eq("R9", "general call refused", {31'h0, ak}, 32'h0);
    m_stop();
    wait_cyc(40);
    check_eq("R9", "no irq for refused general call", {31'h0, irq}, 32'h0);

    // R10: byte received with ack_en low
    exp_q.push_back(mk(8'h60, 8'h00, 8'h00, 1'b0));
    exp_q.push_back(mk(8'h88, 8'h5A, 8'h00, 1'b1));
    m_start();
    send_byte(8'h74, ak); check_eq("R2", "address ack", {31'h0, ak}, 32'h1);
    send_byte(8'h5A, ak); check_eq("R10", "byte refused", {31'h0, ak}, 32'h0);
    m_stop();
    wait_cyc(40);

    check_eq("R5", "all expected events seen", exp_q.size(), 32'h0);
    finish_run();
  end
endmodule